// File: doc/BRIEF.md
# Two-Contestant First-Press Lockout

This block decides which of two quiz contestants pressed first. It takes three raw, active-high momentary buttons (contestant A, contestant B and the quiz master's clear), brings each into the clock domain through a synchroniser and filters contact bounce with a counter. Each contestant owns a one-bit latch. The latch sets on the rising edge of that contestant's filtered press, and only while the rival's latch is clear. Once one latch holds, the other contestant is locked out until the quiz master clears the round.

The clear button outranks both contestants. While it is held, both lamps stay dark and presses are thrown away. Because latches respond to press edges and not to levels, a button still held down when the clear is released has no effect until it is pressed again. If both filtered presses arrive in the same cycle, contestant A takes the round by a fixed tie-break, so that exactly one lamp lights. A busy output shows that the round has been claimed.

Top module: `quiz_lockout`

## Requirements
- R1: While `rst_n` is low, and after it is released with no press, `lamp_a`, `lamp_b` and `busy` are all 0.
- R2: A press held on `btn_a_raw` turns `lamp_a` on, and `lamp_a` stays on after the button is released.
- R3: A press held on `btn_b_raw` turns `lamp_b` on, and `lamp_b` stays on after the button is released.
- R4: While one lamp is on, presses of the other contestant's button have no effect on either lamp.
- R5: A debounced press of `btn_clr_raw` turns both lamps off. While it is held, contestant presses are ignored. Clear wins over a contestant press whose filtered edge falls in the same cycle.
- R6: If both contestants' filtered press edges arrive in the same cycle with both lamps off, only `lamp_a` turns on.
- R7: A contestant button held down through the release of the clear does not light its lamp until it is released and pressed again.
- R8: A raw level must be seen on the synchronised input for `DEBOUNCE_CYCLES` consecutive cycles to be accepted. A pulse shorter than that lights nothing.
- R9: `lamp_a` goes high exactly at the (`DEBOUNCE_CYCLES`+3)th rising clock edge after `btn_a_raw` goes high (two synchroniser stages, the filter, and the latch).
- R10: `busy` is 1 exactly when either lamp is on, and the two lamps are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_a_raw | input | 1 | Contestant A button, raw, active high |
| btn_b_raw | input | 1 | Contestant B button, raw, active high |
| btn_clr_raw | input | 1 | Quiz-master clear button, raw, active high |
| lamp_a | output | 1 | Contestant A has claimed the round |
| lamp_b | output | 1 | Contestant B has claimed the round |
| busy | output | 1 | Either lamp is on |

## Verification
Two events can fall in the same cycle: two contestant press edges, or a contestant press edge and a clear edge. The bench provokes each case by changing the raw inputs at the same falling clock edge. Identical synchroniser and filter paths then deliver the filtered edges to the latches together. For the first case the bench checks that only `lamp_a` lights. For the second it checks that both lamps end dark. It then releases the clear with the contestant still held and confirms that the lamp stays dark until the contestant presses again.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int NUM_BTN = 3;
  typedef enum int unsigned {
    BTN_A   = 0,
    BTN_B   = 1,
    BTN_CLR = 2
  } btn_idx_e;
endpackage

// File: rtl/quiz_rst_sync.sv
module quiz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/quiz_btn_filter.sv
module quiz_btn_filter #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_o,
  output logic rise_o
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;
  logic                   rise_q, rise_d;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_in};
    cnt_d  = '0;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    if (samp != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d  = samp;
        rise_d = samp;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;

  // R8: an accepted edge is a single-cycle event
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);
  // R8: the filtered level only moves when the synchronised input disagreed with it
  assert_level_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/quiz_lockout_core.sv
module quiz_lockout_core (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_a,
  input  logic rise_b,
  input  logic clr_level,
  output logic held_a,
  output logic held_b
);
  logic a_q, a_d, b_q, b_d;
  logic take_a, take_b;

  always_comb begin
    take_a = rise_a && !b_q;
    take_b = rise_b && !a_q && !take_a;
    if (clr_level) begin
      a_d = 1'b0;
      b_d = 1'b0;
    end else begin
      a_d = a_q || take_a;
      b_d = b_q || take_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign held_a = a_q;
  assign held_b = b_q;

  assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_q && b_q));
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_level |=> (!a_q && !b_q));
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q && !clr_level) |=> a_q);
  assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q && !clr_level) |=> !a_q);
  assert_tie_to_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_a && rise_b && !a_q && !b_q && !clr_level) |=> (a_q && !b_q));
endmodule

// File: rtl/quiz_lockout.sv
module quiz_lockout #(
  parameter int SYNC_STAGES     = 2,
  parameter int RST_STAGES      = 2,
  parameter int DEBOUNCE_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_a_raw,
  input  logic btn_b_raw,
  input  logic btn_clr_raw,
  output logic lamp_a,
  output logic lamp_b,
  output logic busy
);
  import quiz_pkg::*;

  logic               rst_n_s;
  logic [NUM_BTN-1:0] raw_vec, lvl_vec, rise_vec;

  assign raw_vec[BTN_A]   = btn_a_raw;
  assign raw_vec[BTN_B]   = btn_b_raw;
  assign raw_vec[BTN_CLR] = btn_clr_raw;

  quiz_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    quiz_btn_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) u_filt (
      .clk(clk), .rst_n(rst_n_s), .raw_in(raw_vec[i]),
      .level_o(lvl_vec[i]), .rise_o(rise_vec[i]));
  end

  quiz_lockout_core u_core (
    .clk(clk), .rst_n(rst_n_s),
    .rise_a(rise_vec[BTN_A]), .rise_b(rise_vec[BTN_B]),
    .clr_level(lvl_vec[BTN_CLR]),
    .held_a(lamp_a), .held_b(lamp_b));

  assign busy = lamp_a | lamp_b;

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(!lamp_a && !lamp_b));
endmodule

// File: tb/quiz_lockout_test.sv
module quiz_lockout_test;
  localparam int DB     = 8;
  localparam int SETTLE = DB + 6;

  logic clk = 1'b0;
  logic rst_n;
  logic a_raw, b_raw, c_raw;
  logic lamp_a, lamp_b, busy;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  quiz_lockout #(.DEBOUNCE_CYCLES(DB)) uut (
    .clk(clk), .rst_n(rst_n), .btn_a_raw(a_raw), .btn_b_raw(b_raw),
    .btn_clr_raw(c_raw), .lamp_a(lamp_a), .lamp_b(lamp_b), .busy(busy));

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {lamp_a,lamp_b,busy} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_btns(input logic a, input logic b, input logic c);
    @(negedge clk);
    a_raw = a; b_raw = b; c_raw = c;
  endtask

  task automatic clear_round();
    set_btns(1'b0, 1'b0, 1'b1);
    wait_cycles(SETTLE);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
  endtask

  task automatic t_reset();
    a_raw = 0; b_raw = 0; c_raw = 0; rst_n = 0;
    wait_cycles(3);
    check("R1 during reset", {lamp_a, lamp_b, busy}, 3'b000);
    @(negedge clk); rst_n = 1;
    wait_cycles(SETTLE);
    check("R1 after release", {lamp_a, lamp_b, busy}, 3'b000);
  endtask

  task automatic t_latency_a();
    set_btns(1'b1, 1'b0, 1'b0);
    wait_cycles(DB + 2);
    check("R9 one edge early", {lamp_a, lamp_b, busy}, 3'b000);
    wait_cycles(1);
    check("R9 on time", {lamp_a, lamp_b, busy}, 3'b101);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R2 stays after release", {lamp_a, lamp_b, busy}, 3'b101);
  endtask

  task automatic t_lockout_b_after_a();
    set_btns(1'b0, 1'b1, 1'b0);
    wait_cycles(SETTLE);
    check("R4 B locked out", {lamp_a, lamp_b, busy}, 3'b101);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    clear_round();
    check("R5 clear", {lamp_a, lamp_b, busy}, 3'b000);
  endtask

  task automatic t_press_b_then_a();
    set_btns(1'b0, 1'b1, 1'b0);
    wait_cycles(SETTLE);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R3 B latched", {lamp_a, lamp_b, busy}, 3'b011);
    set_btns(1'b1, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R4 A locked out", {lamp_a, lamp_b, busy}, 3'b011);
    clear_round();
    check("R5 clear B", {lamp_a, lamp_b, busy}, 3'b000);
  endtask

  task automatic t_tie();
    set_btns(1'b1, 1'b1, 1'b0);
    wait_cycles(SETTLE);
    check("R6 tie goes to A", {lamp_a, lamp_b, busy}, 3'b101);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R10 single lamp after tie", {lamp_a, lamp_b, busy}, 3'b101);
    clear_round();
  endtask

  task automatic t_clear_vs_press();
    set_btns(1'b0, 1'b1, 1'b1);
    wait_cycles(SETTLE);
    check("R5 clear beats same-cycle press", {lamp_a, lamp_b, busy}, 3'b000);
    set_btns(1'b1, 1'b1, 1'b1);
    wait_cycles(SETTLE);
    check("R5 press ignored while clear held", {lamp_a, lamp_b, busy}, 3'b000);
    set_btns(1'b1, 1'b1, 1'b0);
    wait_cycles(SETTLE);
    check("R7 held through clear release", {lamp_a, lamp_b, busy}, 3'b000);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    set_btns(1'b0, 1'b1, 1'b0);
    wait_cycles(SETTLE);
    check("R7 re-press registers", {lamp_a, lamp_b, busy}, 3'b011);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    clear_round();
  endtask

  task automatic t_glitch();
    set_btns(1'b1, 1'b0, 1'b0);
    wait_cycles(DB - 1);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R8 short pulse rejected", {lamp_a, lamp_b, busy}, 3'b000);
    set_btns(1'b1, 1'b0, 1'b0);
    wait_cycles(DB);
    set_btns(1'b0, 1'b0, 1'b0);
    wait_cycles(SETTLE);
    check("R8 full-length pulse accepted", {lamp_a, lamp_b, busy}, 3'b101);
    clear_round();
  endtask

  initial begin
    t_reset();
    t_latency_a();
    t_lockout_b_after_a();
    t_press_b_then_a();
    t_tie();
    t_clear_vs_press();
    t_glitch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule